// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a 34-bit physical address by walking a two-level page table in memory. Pages are 4 KiB. Each level is indexed by a 10-bit slice of the virtual page number, and every table entry is one 32-bit word. A requester presents an address together with the access kind (load, store or instruction fetch), the effective privilege and two status bits. The first status bit lets supervisor code reach user pages. The second lets loads read pages that are only executable. The root table page number and a paged/bare mode bit come in as plain inputs.

The walker takes one request, reads at most two entries through a single-word memory port with a ready/valid handshake, and applies the full rule set to the leaf it finds. The rules cover validity, reserved encodings, the user/supervisor split, superpage alignment and access rights. If the walk succeeds and the leaf's accessed bit (or, for a store, its dirty bit) is not already set, the walker writes the updated entry back in place. It then pulses `done` for one cycle with either a fault or a physical address plus read/write/execute rights. Requests in bare mode or at machine privilege skip the walk.

Top module: `ptw_walker`

## Requirements
- R1: When `pagedMode` is 0 or `reqPriv` is 3 (machine), no memory access is made and `done` rises in the cycle after acceptance with `fault`=0, `physAddr` equal to the virtual address zero-extended, and all three rights set.
- R2: The first entry is read at rootPpn·4096 + va[31:22]·4. An entry with valid set and R, W, X all zero points on, and the second read is at its page number·4096 + va[21:12]·4. A pointer found at the second level faults.
- R3: The entry layout is valid bit 0, R bit 1, W bit 2, X bit 3, U bit 4, accessed bit 6, dirty bit 7, and page number bits 31:10. An entry with valid clear faults. A leaf with W set and R clear (W-only, or W with X) is reserved and faults.
- R4: Privilege codes are 0 user, 1 supervisor and 3 machine. A leaf with U set faults unless the privilege is user, or `reqSum` is set and the access is not a fetch. A leaf with U clear faults unless the privilege is supervisor.
- R5: A first-level leaf whose page number bits [9:0] are not all zero faults as a misaligned superpage.
- R6: Access codes are 0 load, 1 store and 2 fetch. A load needs R, or X together with `reqMxr`. A store needs W. A fetch needs X. Otherwise the access faults.
- R7: On success the walker computes the entry with the accessed bit set, and with the dirty bit also set for a store. It writes that entry to the leaf's address only if it differs from the value read. A fault never writes.
- R8: On success, `physAddr` is page number·4096 + va[11:0] for a second-level leaf. For a superpage it is {page number[21:10], va[21:0]}.
- R9: The reported read right is R, or X with `reqMxr`. The execute right is X. The write right is W together with either a store or an entry that is already dirty. On a fault all three are 0.
- R10: `busy` rises on acceptance and stays high through the single-cycle `done` pulse. `reqValid` is ignored while `busy` is high. A memory request holds its address and data until `memReady`, and no request is made while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when idle |
| reqVaddr | input | 32 | Virtual address |
| reqAccess | input | 2 | 0 load, 1 store, 2 fetch |
| reqPriv | input | 2 | 0 user, 1 supervisor, 3 machine |
| reqSum | input | 1 | Supervisor may use user pages |
| reqMxr | input | 1 | Loads may use execute-only pages |
| rootPpn | input | 22 | Root table page number |
| pagedMode | input | 1 | 1 walks tables, 0 passes through |
| memReqValid | output | 1 | Memory request pending |
| memReqWrite | output | 1 | Pending request is a write |
| memAddr | output | 34 | Word address of the entry (byte units) |
| memWdata | output | 32 | Entry value to write |
| memReady | input | 1 | Memory completes the request this cycle |
| memRdata | input | 32 | Read data, valid with memReady |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Translation failed |
| physAddr | output | 34 | Translated address |
| permR | output | 1 | Read right |
| permW | output | 1 | Write right |
| permX | output | 1 | Execute right |

## Verification
A pass-through result is due in the cycle right after the accepting edge. The bench therefore checks that `done` is already high at the first falling edge after the request. A walked result is due in the cycle after the last memory handshake, whether that handshake is the final read or the write-back. The bench's memory model records the cycle of each handshake, and the bench requires `done` to be seen exactly one cycle later. It then requires `done` and `busy` to be low one cycle after that. Memory readiness follows a pseudo-random pattern, so every beat is tested both with and without stalls. Every result is sampled on a falling edge.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int OFF_W = 12;
  localparam int IDX_W = 10;
  localparam int PPN_W = 22;
  localparam int PTE_W = 32;
  localparam int VA_W  = OFF_W + 2 * IDX_W;
  localparam int PA_W  = PPN_W + OFF_W;
  localparam int ENT_SHIFT = $clog2(PTE_W / 8);

  localparam int PTE_V = 0;
  localparam int PTE_R = 1;
  localparam int PTE_W_BIT = 2;
  localparam int PTE_X = 3;
  localparam int PTE_U = 4;
  localparam int PTE_A = 6;
  localparam int PTE_D = 7;

  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  typedef enum logic [1:0] {
    CLS_FAULT,
    CLS_NEXT,
    CLS_LEAF_KEEP,
    CLS_LEAF_WRITE
  } pteClass_e;

  typedef struct packed {
    logic capture;
    logic descend;
    logic takeLeaf;
    logic takeFault;
  } ctrlStrobe_t;
endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl import ptw_pkg::*; (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        bypass,
  input  logic        memReady,
  input  pteClass_e   pteClass,
  output ctrlStrobe_t strobe,
  output logic        memReqValid,
  output logic        memReqWrite,
  output logic        busy,
  output logic        done
);
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_FINISH} state_e;
  state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.capture = 1'b1;
          stateNext = bypass ? ST_FINISH : ST_READ;
        end
      end
      ST_READ: begin
        if (memReady) begin
          case (pteClass)
            CLS_NEXT:       strobe.descend = 1'b1;
            CLS_LEAF_KEEP: begin
              strobe.takeLeaf = 1'b1;
              stateNext = ST_FINISH;
            end
            CLS_LEAF_WRITE: begin
              strobe.takeLeaf = 1'b1;
              stateNext = ST_WRITE;
            end
            default: begin
              strobe.takeFault = 1'b1;
              stateNext = ST_FINISH;
            end
          endcase
        end
      end
      ST_WRITE:  if (memReady) stateNext = ST_FINISH;
      default:   stateNext = ST_IDLE;
    endcase
  end

  assign memReqValid = (state == ST_READ) || (state == ST_WRITE);
  assign memReqWrite = (state == ST_WRITE);
  assign busy        = (state != ST_IDLE);
  assign done        = (state == ST_FINISH);
endmodule

// File: rtl/ptw_dpath.sv
module ptw_dpath import ptw_pkg::*; (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic [1:0]       reqAccess,
  input  logic [1:0]       reqPriv,
  input  logic             reqSum,
  input  logic             reqMxr,
  input  logic [PPN_W-1:0] rootPpn,
  input  logic             pagedMode,
  input  logic [PTE_W-1:0] memRdata,
  output logic             bypass,
  output pteClass_e        pteClass,
  output logic [PA_W-1:0]  memAddr,
  output logic [PTE_W-1:0] memWdata,
  output logic [PA_W-1:0]  physAddr,
  output logic             permR,
  output logic             permW,
  output logic             permX,
  output logic             fault
);
  logic [VA_W-1:0]  vaddr;
  logic [1:0]       access, priv;
  logic             sum, mxr;
  logic             topLevel;
  logic [PPN_W-1:0] basePpn;
  logic [PTE_W-1:0] newPte;

  logic [IDX_W-1:0] idx;
  logic [PPN_W-1:0] ptePpn;
  logic pteV, pteR, pteW, pteX, pteU, pteD;
  logic isLoad, isStore, isFetch;
  logic [PTE_W-1:0] updatedPte;
  logic [PA_W-1:0]  leafAddr;

  assign bypass = !pagedMode || (reqPriv == PRIV_M);

  assign idx     = topLevel ? vaddr[VA_W-1 -: IDX_W] : vaddr[OFF_W +: IDX_W];
  assign memAddr = {basePpn, idx, ENT_SHIFT'(0)};
  assign memWdata = newPte;

  assign ptePpn = memRdata[PTE_W-1 -: PPN_W];
  assign pteV = memRdata[PTE_V];
  assign pteR = memRdata[PTE_R];
  assign pteW = memRdata[PTE_W_BIT];
  assign pteX = memRdata[PTE_X];
  assign pteU = memRdata[PTE_U];
  assign pteD = memRdata[PTE_D];

  assign isLoad  = (access == ACC_LOAD);
  assign isStore = (access == ACC_STORE);
  assign isFetch = (access == ACC_FETCH);

  assign updatedPte = memRdata | (PTE_W'(1) << PTE_A) | (isStore ? (PTE_W'(1) << PTE_D) : '0);
  assign leafAddr = topLevel ? {ptePpn[PPN_W-1:IDX_W], vaddr[OFF_W+IDX_W-1:0]}
                             : {ptePpn, vaddr[OFF_W-1:0]};

  always_comb begin
    pteClass = CLS_FAULT;
    if (!pteV) begin
      pteClass = CLS_FAULT;
    end else if (!pteR && !pteW && !pteX) begin
      pteClass = topLevel ? CLS_NEXT : CLS_FAULT;
    end else if (pteW && !pteR) begin
      pteClass = CLS_FAULT;
    end else if (pteU && (priv != PRIV_U) && (!sum || isFetch)) begin
      pteClass = CLS_FAULT;
    end else if (!pteU && (priv != PRIV_S)) begin
      pteClass = CLS_FAULT;
    end else if (topLevel && (ptePpn[IDX_W-1:0] != '0)) begin
      pteClass = CLS_FAULT;
    end else if ((isLoad && !(pteR || (pteX && mxr))) ||
                 (isStore && !pteW) || (isFetch && !pteX)) begin
      pteClass = CLS_FAULT;
    end else begin
      pteClass = (updatedPte != memRdata) ? CLS_LEAF_WRITE : CLS_LEAF_KEEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddr <= '0; access <= '0; priv <= '0; sum <= 1'b0; mxr <= 1'b0;
      topLevel <= 1'b1; basePpn <= '0; newPte <= '0;
      physAddr <= '0; permR <= 1'b0; permW <= 1'b0; permX <= 1'b0; fault <= 1'b0;
    end else begin
      if (strobe.capture) begin
        vaddr <= reqVaddr; access <= reqAccess; priv <= reqPriv;
        sum <= reqSum; mxr <= reqMxr;
        topLevel <= 1'b1;
        basePpn <= rootPpn;
        fault <= 1'b0;
        physAddr <= bypass ? PA_W'(reqVaddr) : '0;
        permR <= bypass; permW <= bypass; permX <= bypass;
      end
      if (strobe.descend) begin
        basePpn  <= ptePpn;
        topLevel <= 1'b0;
      end
      if (strobe.takeLeaf) begin
        newPte   <= updatedPte;
        physAddr <= leafAddr;
        permR    <= pteR || (pteX && mxr);
        permW    <= pteW && (isStore || pteD);
        permX    <= pteX;
      end
      if (strobe.takeFault) begin
        fault <= 1'b1;
        physAddr <= '0;
        permR <= 1'b0; permW <= 1'b0; permX <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker import ptw_pkg::*; (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic [1:0]       reqAccess,
  input  logic [1:0]       reqPriv,
  input  logic             reqSum,
  input  logic             reqMxr,
  input  logic [PPN_W-1:0] rootPpn,
  input  logic             pagedMode,
  output logic             memReqValid,
  output logic             memReqWrite,
  output logic [PA_W-1:0]  memAddr,
  output logic [PTE_W-1:0] memWdata,
  input  logic             memReady,
  input  logic [PTE_W-1:0] memRdata,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic [PA_W-1:0]  physAddr,
  output logic             permR,
  output logic             permW,
  output logic             permX
);
  ctrlStrobe_t strobe;
  pteClass_e   pteClass;
  logic        bypass;

  ptw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .bypass(bypass),
    .memReady(memReady), .pteClass(pteClass), .strobe(strobe),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite),
    .busy(busy), .done(done)
  );

  ptw_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqVaddr(reqVaddr), .reqAccess(reqAccess), .reqPriv(reqPriv),
    .reqSum(reqSum), .reqMxr(reqMxr), .rootPpn(rootPpn), .pagedMode(pagedMode),
    .memRdata(memRdata), .bypass(bypass), .pteClass(pteClass),
    .memAddr(memAddr), .memWdata(memWdata), .physAddr(physAddr),
    .permR(permR), .permW(permW), .permX(permX), .fault(fault)
  );
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk import ptw_pkg::*; (
  input logic             clk,
  input logic             rstN,
  input logic             memReqValid,
  input logic             memReqWrite,
  input logic [PA_W-1:0]  memAddr,
  input logic [PTE_W-1:0] memWdata,
  input logic             memReady,
  input logic             busy,
  input logic             done,
  input logic             fault,
  input logic             permR,
  input logic             permW,
  input logic             permX
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10
  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy); // R10
  AST_NO_MEM_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReqValid); // R10
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReady) |=> (memReqValid && $stable(memAddr) &&
                                    $stable(memReqWrite) && $stable(memWdata))); // R10
  AST_WRITE_SETS_A: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite) |-> memWdata[PTE_A]); // R7
  AST_FAULT_NO_RIGHTS: assert property (@(posedge clk) disable iff (!rstN)
    (done && fault) |-> (!permR && !permW && !permX)); // R9
  AST_WRITE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rstN)
    (done && !fault && permW) |-> permR); // R3
endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk(clk), .rstN(rstN), .memReqValid(memReqValid), .memReqWrite(memReqWrite),
  .memAddr(memAddr), .memWdata(memWdata), .memReady(memReady), .busy(busy),
  .done(done), .fault(fault), .permR(permR), .permW(permW), .permX(permX)
);

// File: tb/ptw_walker_bench.sv
`timescale 1ns/1ps
module ptw_walker_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic [1:0] reqAccess = '0, reqPriv = '0;
  logic reqSum = 1'b0, reqMxr = 1'b0;
  logic [21:0] rootPpn = 22'd1;
  logic pagedMode = 1'b1;
  logic memReqValid, memReqWrite, memReady;
  logic [33:0] memAddr;
  logic [31:0] memWdata, memRdata;
  logic busy, done, fault, permR, permW, permX;
  logic [33:0] physAddr;

  int checks = 0, fails = 0;
  int cycle = 0, hsTotal = 0, wrTotal = 0, lastHs = -5;
  logic [33:0] lastRd = '0, prevRd = '0;
  logic [7:0] lfsr = 8'hA5;
  logic [31:0] mem [0:4095] = '{default: '0};
  logic bdWe = 1'b0;
  logic [11:0] bdIdx = '0;
  logic [31:0] bdData = '0;

  always #10 clk = ~clk;

  ptw_walker u_ptw_walker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .reqAccess(reqAccess), .reqPriv(reqPriv), .reqSum(reqSum), .reqMxr(reqMxr),
    .rootPpn(rootPpn), .pagedMode(pagedMode), .memReqValid(memReqValid),
    .memReqWrite(memReqWrite), .memAddr(memAddr), .memWdata(memWdata),
    .memReady(memReady), .memRdata(memRdata), .busy(busy), .done(done),
    .fault(fault), .physAddr(physAddr), .permR(permR), .permW(permW), .permX(permX)
  );

  assign memReady = lfsr[0] | lfsr[3];
  assign memRdata = mem[memAddr[13:2]];

  always @(posedge clk) begin
    cycle <= cycle + 1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (bdWe) mem[bdIdx] <= bdData;
    if (rstN && memReqValid && memReady) begin
      hsTotal <= hsTotal + 1;
      lastHs <= cycle;
      if (memReqWrite) begin
        mem[memAddr[13:2]] <= memWdata;
        wrTotal <= wrTotal + 1;
      end else begin
        prevRd <= lastRd;
        lastRd <= memAddr;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic poke(input logic [11:0] idx, input logic [31:0] data);
    @(negedge clk);
    bdWe = 1'b1; bdIdx = idx; bdData = data;
    @(negedge clk);
    bdWe = 1'b0;
  endtask

  // Expected result built from the requirement text, reading the bench memory.
  task automatic model(input logic [31:0] va, input logic [1:0] acc, pr,
                       input logic su, mx, pg,
                       output logic eFault, output logic [33:0] ePa,
                       output logic eR, eW, eX, output int eReads,
                       output logic [33:0] eA1, eA2, output logic eWrite,
                       output logic [33:0] eWAddr, output logic [31:0] eNew,
                       output string eTag);
    logic [31:0] pte;
    logic [33:0] a;
    int lv;
    logic r, w, x, u;
    eFault = 1'b0; ePa = '0; eR = 0; eW = 0; eX = 0; eReads = 0;
    eA1 = '0; eA2 = '0; eWrite = 0; eWAddr = '0; eNew = '0; eTag = "R1";
    if (!pg || pr == 2'd3) begin
      ePa = {2'b00, va}; eR = 1; eW = 1; eX = 1;
      return;
    end
    a = {12'(0), rootPpn} * 34'd4096 + 34'(va[31:22]) * 34'd4;
    eA1 = a; eReads = 1; lv = 1;
    pte = mem[a[13:2]];
    if (pte[0] && pte[3:1] == 3'b000) begin
      a = {12'(0), pte[31:10]} * 34'd4096 + 34'(va[21:12]) * 34'd4;
      eA2 = a; eReads = 2; lv = 0;
      pte = mem[a[13:2]];
    end
    r = pte[1]; w = pte[2]; x = pte[3]; u = pte[4];
    eFault = 1'b1;
    if (!pte[0]) eTag = "R3";
    else if (!r && !w && !x) eTag = "R2";
    else if (w && !r) eTag = "R3";
    else if (u ? (pr != 2'd0 && !(su && acc != 2'd2)) : (pr != 2'd1)) eTag = "R4";
    else if (lv == 1 && pte[19:10] != 10'd0) eTag = "R5";
    else if ((acc == 2'd0 && !(r || (x && mx))) || (acc == 2'd1 && !w) ||
             (acc == 2'd2 && !x)) eTag = "R6";
    else begin
      eFault = 1'b0; eTag = "R6";
      eNew = pte | 32'h40 | ((acc == 2'd1) ? 32'h80 : 32'h0);
      eWrite = (eNew != pte);
      eWAddr = a;
      ePa = (lv == 1) ? {pte[31:20], va[21:0]} : {pte[31:10], va[11:0]};
      eR = r || (x && mx); eX = x; eW = w && (acc == 2'd1 || pte[7]);
    end
  endtask

  task automatic doWalk(input logic [31:0] va, input logic [1:0] acc, pr,
                        input logic su, mx, pg, ju, input logic [31:0] junkVa);
    logic eFault, eR, eW, eX, eWrite;
    logic [33:0] ePa, eA1, eA2, eWAddr;
    logic [31:0] eNew;
    int eReads, hs0, wr0, n;
    string eTag;
    model(va, acc, pr, su, mx, pg, eFault, ePa, eR, eW, eX, eReads, eA1, eA2,
          eWrite, eWAddr, eNew, eTag);
    @(negedge clk);
    hs0 = hsTotal; wr0 = wrTotal;
    reqVaddr = va; reqAccess = acc; reqPriv = pr; reqSum = su; reqMxr = mx;
    pagedMode = pg; reqValid = 1'b1;
    @(negedge clk);
    if (ju) reqVaddr = junkVa;
    else reqValid = 1'b0;
    n = 0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    reqValid = 1'b0;
    chk(done, "R10", "done seen", 64'(done), 64'h1);
    chk(busy, "R10", "busy during done", 64'(busy), 64'h1);
    if (eReads == 0) begin
      chk(n == 0, "R1", "pass-through latency", 64'(n), 64'h0);
    end else begin
      chk(cycle == lastHs + 1, "R10", "done one cycle after last beat",
          64'(cycle), 64'(lastHs + 1));
    end
    chk(fault == eFault, eTag, "fault", 64'(fault), 64'(eFault));
    chk(physAddr == ePa, eReads == 0 ? "R1" : "R8", "physAddr", 64'(physAddr), 64'(ePa));
    chk({permR, permW, permX} == {eR, eW, eX}, eReads == 0 ? "R1" : "R9", "rights",
        64'({permR, permW, permX}), 64'({eR, eW, eX}));
    chk(hsTotal - hs0 == eReads + int'(eWrite), "R7", "memory beats",
        64'(hsTotal - hs0), 64'(eReads + int'(eWrite)));
    chk(wrTotal - wr0 == int'(eWrite), "R7", "write count",
        64'(wrTotal - wr0), 64'(eWrite));
    if (eWrite) chk(mem[eWAddr[13:2]] == eNew, "R7", "entry written back",
                    64'(mem[eWAddr[13:2]]), 64'(eNew));
    if (eReads == 1) chk(lastRd == eA1, "R2", "first entry address", 64'(lastRd), 64'(eA1));
    if (eReads == 2) begin
      chk(prevRd == eA1, "R2", "first entry address", 64'(prevRd), 64'(eA1));
      chk(lastRd == eA2, "R2", "second entry address", 64'(lastRd), 64'(eA2));
    end
    @(negedge clk);
    chk(!done && !busy, "R10", "idle after pulse", 64'({done, busy}), 64'h0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10 watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int k;
    logic [9:0] v1, v0;
    logic [11:0] off;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !memReqValid, "R10", "reset state",
        64'({busy, done, memReqValid}), 64'h0);

    // R1: pass-through cases
    doWalk(32'hDEADBEEF, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    doWalk(32'h00000FFF, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    doWalk(32'hFFFFF000, 2'd2, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0);
    doWalk(32'h12345678, 2'd1, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 32'h87654321);

    // Second-level leaf: every flag byte, access, privilege, SUM and MXR
    k = 0;
    for (int fl = 0; fl < 256; fl++)
      for (int acc = 0; acc < 3; acc++)
        for (int pr = 0; pr < 2; pr++)
          for (int sm = 0; sm < 4; sm++) begin
            v1 = 10'((k * 7) % 1024);
            v0 = 10'((k * 13 + 5) % 1024);
            off = 12'((k * 37) % 4096);
            poke(12'h400 + 12'(v1), 32'h0000_0801);
            poke(12'h800 + 12'(v0), {22'h12345, 10'(fl)});
            doWalk({v1, v0, off}, 2'(acc), 2'(pr), sm[0], sm[1], 1'b1,
                   (k % 97) == 3, ~{v1, v0, off});
            k++;
          end

    // First-level leaf (superpage): aligned and misaligned page numbers
    for (int fl = 0; fl < 256; fl++) begin
      if (fl[3:1] == 3'b000) continue;
      for (int acc = 0; acc < 3; acc++)
        for (int pr = 0; pr < 2; pr++)
          for (int sm = 0; sm < 4; sm++)
            for (int mis = 0; mis < 2; mis++) begin
              v1 = 10'((k * 11) % 1024);
              v0 = 10'((k * 3 + 1) % 1024);
              off = 12'((k * 29) % 4096);
              poke(12'h400 + 12'(v1), {(mis != 0) ? 22'h12C07 : 22'h12C00, 10'(fl)});
              doWalk({v1, v0, off}, 2'(acc), 2'(pr), sm[0], sm[1], 1'b1, 1'b0, 32'h0);
              k++;
            end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule